// File: doc/BRIEF.md
# Receive Ring Buffer Frame Writer

This block takes received Ethernet frames from the line side and stores each accepted frame in a circular buffer in local RAM. The buffer is a run of 256-byte pages. It starts at a programmable first page and ends just before a programmable stop page. A boundary page marks how far the host has read, and a current page marks where the next frame will be placed. A frame arrives as one byte per valid beat, with start and end flags. The first beat also carries a descriptor: the frame length, the destination address and the 6-bit multicast hash index, which another block computes.

The block decides on the first beat whether to keep the frame. It checks the run state, the free space in the ring, the runt rule and the address filter. A frame that is kept is streamed into RAM from offset 4 of the current page, and the address wraps from the stop page back to the first page. When the last byte has been written, the block fills in the 4-byte header at offset 0 of the page, moves the current page on, updates two receive status bits and pulses a completion event. A frame that is turned away causes no RAM write and changes no state.

Top module: `rx_ring_writer`

## Requirements
- R1: While `cfg_stop` is 1, or while `cfg_page_start` is 0, no frame is accepted: no RAM write occurs and no state changes.
- R2: Pages needed = (length + 263) / 256. Free pages = boundary − current when current < boundary, otherwise (stop − start) − (current − boundary). A frame needing more pages than are free is dropped whole. A frame needing exactly the free count is accepted.
- R3: A frame shorter than 40 bytes is dropped unless `cfg_runt_ok` is 1. An accepted frame shorter than 60 bytes is recorded in its header as 60 bytes.
- R4: With `cfg_promisc` set, every frame passes the filter. Otherwise, destination byte 0 is `rx_dest[7:0]`, and the rules are checked in this order. An all-ones destination needs `cfg_bcast_en`. A destination with bit 0 of byte 0 set needs `cfg_mcast_en` and bit `rx_hash_idx` of `cfg_hash`, where hash byte k is bits [8k+7:8k] and the index selects byte [5:3] and bit [2:0]. Any other destination must equal `cfg_station`.
- R5: Payload bytes are written one per valid beat, in order, starting at address current×256+4. Each write appears on the RAM port one cycle after its beat.
- R6: A payload write that would land on address stop×256 goes instead to start×256, and the following bytes continue from there.
- R7: After the last payload byte, four header writes follow on consecutive cycles at current×256+0..3. Their values are 0x01, the next page, the low byte of (recorded length + 4), and the high byte of (recorded length + 4).
- R8: The next page is current + pages needed. If that value reaches or passes the stop page, (stop − start) is subtracted. The current page takes this value with the last header write.
- R9: On completion, `stat_rx_ok` is set, `stat_mcast` takes bit 0 of destination byte 0, and `rx_done` pulses high for exactly one cycle. The new current page is visible in that same cycle.
- R10: A write of `cur_wdata` through `cur_wr` loads the current page only while no frame is in progress. While a frame is being stored, including the cycle of its last header write, the load is ignored.
- R11: After reset, the current page is 0, both status bits are 0, and `ram_we` and `rx_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stop | input | 1 | Controller stopped; receive disabled |
| cfg_page_start | input | 8 | First page of the ring |
| cfg_page_stop | input | 8 | Page just past the end of the ring |
| cfg_boundary | input | 8 | Host read boundary page |
| cfg_station | input | 48 | Station address, byte 0 in bits [7:0] |
| cfg_hash | input | 64 | Multicast hash table |
| cfg_promisc | input | 1 | Accept every destination |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_en | input | 1 | Accept hashed multicast |
| cfg_runt_ok | input | 1 | Accept frames shorter than 40 bytes |
| cur_wr | input | 1 | Load current page |
| cur_wdata | input | 8 | Value to load into current page |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Frame byte |
| rx_len | input | 16 | Frame length, valid with rx_sof |
| rx_dest | input | 48 | Destination address, valid with rx_sof |
| rx_hash_idx | input | 6 | Multicast hash index, valid with rx_sof |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cur_page | output | 8 | Current page pointer |
| rx_done | output | 1 | Frame stored, one-cycle pulse |
| stat_rx_ok | output | 1 | Receive-OK status |
| stat_mcast | output | 1 | Last stored frame had a group destination |

## Verification
Two functions can meet in one cycle: a host load of the current page, and the commit of the current page that comes with the last header write. To provoke this, the bench holds `cur_wr` high with a marker value from the second payload beat through the last header write. It then checks that the pointer equals the computed next page and never the marker. A second overlap happens when the payload write address crosses the stop page within a frame. There the bench predicts every byte's wrapped address and compares it, in order, against the RAM port traffic. Any extra or missing write counts as a failure.

// File: rtl/rxr_pkg.sv
// Shared types and constants for the receive ring writer.
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BODY = 2'd1,
        ST_HDR  = 2'd2
    } rxr_state_e;

    localparam logic [7:0] HDR_STATUS_OK = 8'h01;
    localparam int         HDR_BYTES     = 4;
    localparam int         CRC_BYTES     = 4;
endpackage

// File: rtl/rxr_filter.sv
// Accept decision for the destination and size of a frame.
// Assumes: destination byte 0 is dest[7:0]; inputs are valid on the first beat.
module rxr_filter #(
    parameter int LEN_W    = 16,
    parameter int RUNT_LEN = 40
) (
    input  logic [47:0]      dest,
    input  logic [47:0]      station,
    input  logic [63:0]      hash_tbl,
    input  logic [5:0]       hash_idx,
    input  logic [LEN_W-1:0] len,
    input  logic             promisc,
    input  logic             bcast_en,
    input  logic             mcast_en,
    input  logic             runt_ok,
    output logic             pass
);
    logic is_bcast;
    logic is_group;
    logic addr_ok;
    logic size_ok;

    // Classify the destination and apply the matching enable.
    always_comb begin
        is_bcast = &dest;
        is_group = dest[0];
        if (promisc)
            addr_ok = 1'b1;
        else if (is_bcast)
            addr_ok = bcast_en;
        else if (is_group)
            addr_ok = mcast_en & hash_tbl[hash_idx];
        else
            addr_ok = (dest == station);
        size_ok = runt_ok | (len >= LEN_W'(RUNT_LEN));
        pass    = addr_ok & size_ok;
    end
endmodule

// File: rtl/rxr_space.sv
// Page arithmetic: pages needed, free pages in the ring, next page.
// Assumes: start < stop and current/boundary lie inside the ring.
module rxr_space #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16,
    parameter int OVH    = 8
) (
    input  logic [PAGE_W-1:0] cur,
    input  logic [PAGE_W-1:0] bnd,
    input  logic [PAGE_W-1:0] start,
    input  logic [PAGE_W-1:0] stop,
    input  logic [LEN_W-1:0]  len,
    output logic              room_ok,
    output logic [PAGE_W-1:0] next_page
);
    localparam int PG_W = LEN_W - 7;
    localparam int CW   = ((PG_W > PAGE_W) ? PG_W : PAGE_W) + 1;

    logic [LEN_W:0] need_sum;
    logic [CW-1:0]  pages;
    logic [CW-1:0]  span;
    logic [CW-1:0]  avail;
    logic [CW-1:0]  nsum;

    // Round length plus overhead up to whole pages, compare with free pages.
    always_comb begin
        need_sum = {1'b0, len} + (LEN_W+1)'(OVH + 255);
        pages    = CW'(need_sum >> 8);
        span     = CW'(stop) - CW'(start);
        if (cur < bnd)
            avail = CW'(bnd) - CW'(cur);
        else
            avail = span - (CW'(cur) - CW'(bnd));
        room_ok = (avail >= pages);
    end

    // Advance the current page and fold it back into the ring.
    always_comb begin
        nsum = CW'(cur) + pages;
        if (nsum >= CW'(stop))
            nsum = nsum - span;
        next_page = PAGE_W'(nsum);
    end
endmodule

// File: rtl/rxr_wrap_inc.sv
// Byte address incrementer that wraps from the stop page to the start page.
// Assumes: the input address lies inside the ring.
module rxr_wrap_inc #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W+7:0] addr,
    input  logic [PAGE_W-1:0] start,
    input  logic [PAGE_W-1:0] stop,
    output logic [PAGE_W+7:0] nxt
);
    localparam int AW = PAGE_W + 8;

    logic [AW-1:0] plus1;

    // Step by one byte, jump to the ring start at the stop boundary.
    always_comb begin
        plus1 = addr + AW'(1);
        if (plus1 == {stop, 8'h00})
            nxt = {start, 8'h00};
        else
            nxt = plus1;
    end
endmodule

// File: rtl/rx_ring_writer.sv
// Stores filtered receive frames into a paged circular buffer.
// The accept decision is made on the first beat. Payload is written from
// offset 4 of the current page, and the 4-byte header goes in after the
// payload. Assumes: the source leaves at least 5 idle cycles between frames
// and keeps the cfg_* inputs steady while a frame is stored.
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W   = 8,
    parameter int LEN_W    = 16,
    parameter int MIN_LEN  = 60,
    parameter int RUNT_LEN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stop,
    input  logic [PAGE_W-1:0] cfg_page_start,
    input  logic [PAGE_W-1:0] cfg_page_stop,
    input  logic [PAGE_W-1:0] cfg_boundary,
    input  logic [47:0]       cfg_station,
    input  logic [63:0]       cfg_hash,
    input  logic              cfg_promisc,
    input  logic              cfg_bcast_en,
    input  logic              cfg_mcast_en,
    input  logic              cfg_runt_ok,
    input  logic              cur_wr,
    input  logic [PAGE_W-1:0] cur_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [47:0]       rx_dest,
    input  logic [5:0]        rx_hash_idx,
    output logic              ram_we,
    output logic [PAGE_W+7:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic [PAGE_W-1:0] cur_page,
    output logic              rx_done,
    output logic              stat_rx_ok,
    output logic              stat_mcast
);
    localparam int AW  = PAGE_W + 8;
    localparam int OVH = HDR_BYTES + CRC_BYTES;

    rxr_state_e        state_q;
    logic [PAGE_W-1:0] cur_q;
    logic [AW-1:0]     wr_ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [PAGE_W-1:0] next_q;
    logic              mc_q;
    logic [1:0]        hdr_idx_q;

    logic              filt_pass;
    logic              room_ok;
    logic [PAGE_W-1:0] next_page;
    logic [AW-1:0]     first_addr;
    logic [AW-1:0]     inc_in;
    logic [AW-1:0]     inc_out;
    logic              rx_enabled;
    logic              accept;
    logic [LEN_W-1:0]  len_eff;
    logic [7:0]        hdr_byte;

    rxr_filter #(.LEN_W(LEN_W), .RUNT_LEN(RUNT_LEN)) u_filter (
        .dest     (rx_dest),
        .station  (cfg_station),
        .hash_tbl (cfg_hash),
        .hash_idx (rx_hash_idx),
        .len      (rx_len),
        .promisc  (cfg_promisc),
        .bcast_en (cfg_bcast_en),
        .mcast_en (cfg_mcast_en),
        .runt_ok  (cfg_runt_ok),
        .pass     (filt_pass)
    );

    rxr_space #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .OVH(OVH)) u_space (
        .cur       (cur_q),
        .bnd       (cfg_boundary),
        .start     (cfg_page_start),
        .stop      (cfg_page_stop),
        .len       (rx_len),
        .room_ok   (room_ok),
        .next_page (next_page)
    );

    rxr_wrap_inc #(.PAGE_W(PAGE_W)) u_inc (
        .addr  (inc_in),
        .start (cfg_page_start),
        .stop  (cfg_page_stop),
        .nxt   (inc_out)
    );

    // First-beat decision and the source address for the incrementer.
    always_comb begin
        rx_enabled = !cfg_stop && (cfg_page_start != '0);
        accept     = (state_q == ST_IDLE) && rx_valid && rx_sof &&
                     rx_enabled && filt_pass && room_ok;
        first_addr = {cur_q, 8'(HDR_BYTES)};
        inc_in     = (state_q == ST_IDLE) ? first_addr : wr_ptr_q;
        len_eff    = (rx_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : rx_len;
    end

    // Header byte chosen by the header step counter.
    always_comb begin
        case (hdr_idx_q)
            2'd0:    hdr_byte = HDR_STATUS_OK;
            2'd1:    hdr_byte = 8'(next_q);
            2'd2:    hdr_byte = len_q[7:0];
            default: hdr_byte = 8'(len_q >> 8);
        endcase
    end

    // Frame sequencer: payload stream, header fill, pointer commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_q      <= '0;
            wr_ptr_q   <= '0;
            len_q      <= '0;
            next_q     <= '0;
            mc_q       <= 1'b0;
            hdr_idx_q  <= 2'd0;
            ram_we     <= 1'b0;
            ram_addr   <= '0;
            ram_wdata  <= '0;
            rx_done    <= 1'b0;
            stat_rx_ok <= 1'b0;
            stat_mcast <= 1'b0;
        end else begin
            ram_we  <= 1'b0;
            rx_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ram_we    <= 1'b1;
                        ram_addr  <= first_addr;
                        ram_wdata <= rx_data;
                        wr_ptr_q  <= inc_out;
                        len_q     <= len_eff + LEN_W'(HDR_BYTES);
                        next_q    <= next_page;
                        mc_q      <= rx_dest[0];
                        hdr_idx_q <= 2'd0;
                        state_q   <= rx_eof ? ST_HDR : ST_BODY;
                    end else if (cur_wr) begin
                        cur_q <= cur_wdata;
                    end
                end
                ST_BODY: begin
                    if (rx_valid) begin
                        ram_we    <= 1'b1;
                        ram_addr  <= wr_ptr_q;
                        ram_wdata <= rx_data;
                        wr_ptr_q  <= inc_out;
                        if (rx_eof)
                            state_q <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    ram_we    <= 1'b1;
                    ram_addr  <= {cur_q, 6'b0, hdr_idx_q};
                    ram_wdata <= hdr_byte;
                    hdr_idx_q <= hdr_idx_q + 2'd1;
                    if (hdr_idx_q == 2'd3) begin
                        cur_q      <= next_q;
                        stat_rx_ok <= 1'b1;
                        stat_mcast <= mc_q;
                        rx_done    <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_page = cur_q;

    // Every RAM write lands inside the configured ring.
    assert_ring_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr[AW-1:8] >= cfg_page_start && ram_addr[AW-1:8] < cfg_page_stop));

    // A first beat while receive is disabled produces no write.
    assert_disabled_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rx_valid && rx_sof && (cfg_stop || cfg_page_start == '0))
        |=> !ram_we);

    // Header steps write into the first four bytes of a page.
    assert_hdr_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR) |=> (ram_we && ram_addr[7:0] < 8'd4));

    // Completion is a single-cycle pulse with receive-OK already set.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);
    assert_done_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> stat_rx_ok);

    // While a frame is in progress the pointer only moves by the commit.
    assert_cur_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(cur_page) || rx_done));
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_stop, cfg_promisc, cfg_bcast_en, cfg_mcast_en, cfg_runt_ok;
    logic [7:0]  cfg_page_start, cfg_page_stop, cfg_boundary;
    logic [47:0] cfg_station;
    logic [63:0] cfg_hash;
    logic        cur_wr;
    logic [7:0]  cur_wdata;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic [15:0] rx_len;
    logic [47:0] rx_dest;
    logic [5:0]  rx_hash_idx;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  cur_page;
    logic        rx_done, stat_rx_ok, stat_mcast;

    always #5 clk = ~clk;

    rx_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_stop(cfg_stop),
        .cfg_page_start(cfg_page_start), .cfg_page_stop(cfg_page_stop),
        .cfg_boundary(cfg_boundary), .cfg_station(cfg_station), .cfg_hash(cfg_hash),
        .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
        .cfg_mcast_en(cfg_mcast_en), .cfg_runt_ok(cfg_runt_ok),
        .cur_wr(cur_wr), .cur_wdata(cur_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_len(rx_len), .rx_dest(rx_dest), .rx_hash_idx(rx_hash_idx),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cur_page(cur_page), .rx_done(rx_done),
        .stat_rx_ok(stat_rx_ok), .stat_mcast(stat_mcast)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    logic [7:0] bm_cur;

    // Scoreboard queues: expected RAM writes and completion events.
    logic [15:0] q_addr[$];
    logic [7:0]  q_data[$];
    string       q_tag[$];
    logic [7:0]  q_ev_next[$];
    logic        q_ev_mc[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pbyte(input logic [47:0] d, input int i, input int len);
        if (i < 6) return d[8*i +: 8];
        return 8'(i * 13 + len);
    endfunction

    // Reference accept rule from the requirements (R1..R4).
    function automatic bit bm_accept(input logic [47:0] d, input int len, input logic [5:0] hi);
        int pages;
        int avail;
        if (cfg_stop || cfg_page_start == 8'h00) return 1'b0;             // R1
        pages = (len + 263) / 256;                                         // R2
        if (bm_cur < cfg_boundary) avail = int'(cfg_boundary) - int'(bm_cur);
        else avail = (int'(cfg_page_stop) - int'(cfg_page_start)) - (int'(bm_cur) - int'(cfg_boundary));
        if (avail < pages) return 1'b0;
        if (len < 40 && !cfg_runt_ok) return 1'b0;                         // R3
        if (cfg_promisc) return 1'b1;                                      // R4
        if (d == 48'hFFFF_FFFF_FFFF) return cfg_bcast_en;
        if (d[0]) return cfg_mcast_en && cfg_hash[hi];
        return d == cfg_station;
    endfunction

    // Driver: predicts writes and events, then streams the frame.
    task automatic send_frame(input logic [47:0] d, input int len, input logic [5:0] hi,
                              input bit hold_load, input string tag);
        bit acc;
        int pages;
        int nxt;
        int stored;
        logic [15:0] a;
        bit wrapped;
        acc = bm_accept(d, len, hi);
        if (acc) begin
            pages = (len + 263) / 256;
            nxt = int'(bm_cur) + pages;                                    // R8
            if (nxt >= int'(cfg_page_stop)) nxt -= int'(cfg_page_stop) - int'(cfg_page_start);
            a = {bm_cur, 8'h04};
            wrapped = 1'b0;
            for (int i = 0; i < len; i++) begin
                q_addr.push_back(a);
                q_data.push_back(pbyte(d, i, len));
                q_tag.push_back(wrapped ? "R6" : "R5");
                a = a + 16'd1;
                if (a == {cfg_page_stop, 8'h00}) begin
                    a = {cfg_page_start, 8'h00};
                    wrapped = 1'b1;
                end
            end
            stored = ((len < 60) ? 60 : len) + 4;                          // R3 R7
            q_addr.push_back({bm_cur, 8'h00}); q_data.push_back(8'h01);             q_tag.push_back("R7");
            q_addr.push_back({bm_cur, 8'h01}); q_data.push_back(8'(nxt));           q_tag.push_back("R7");
            q_addr.push_back({bm_cur, 8'h02}); q_data.push_back(8'(stored));        q_tag.push_back("R7");
            q_addr.push_back({bm_cur, 8'h03}); q_data.push_back(8'(stored >> 8));   q_tag.push_back("R7");
            q_ev_next.push_back(8'(nxt));
            q_ev_mc.push_back(d[0]);
            bm_cur = 8'(nxt);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_data = pbyte(d, i, len);
            rx_len = 16'(len);
            rx_dest = d;
            rx_hash_idx = hi;
            cur_wr = hold_load && (i > 0);
            cur_wdata = 8'hEE;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (hold_load) repeat (3) @(negedge clk);
        @(negedge clk);
        cur_wr = 1'b0;
        repeat (6) @(negedge clk);
        chk(cur_page == bm_cur, tag, "current page after frame", cur_page, bm_cur);
    endtask

    task automatic load_cur(input logic [7:0] v);
        @(negedge clk); cur_wr = 1'b1; cur_wdata = v;
        @(negedge clk); cur_wr = 1'b0;
        bm_cur = v;
        @(negedge clk);
        chk(cur_page == v, "R10", "idle pointer load", cur_page, v);
    endtask

    // Monitor: compares RAM traffic and completion events with predictions.
    always @(negedge clk) begin
        if (running && rst_n) begin
            if (ram_we) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R2", "unexpected RAM write addr", ram_addr, 0);
                end else begin
                    logic [15:0] ea;
                    logic [7:0]  ed;
                    string       et;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    et = q_tag.pop_front();
                    chk(ram_addr == ea, et, "write address", ram_addr, ea);
                    chk(ram_wdata == ed, et, "write data", ram_wdata, ed);
                end
            end
            if (rx_done) begin
                if (q_ev_next.size() == 0) begin
                    chk(1'b0, "R9", "unexpected completion", 1, 0);
                end else begin
                    logic [7:0] en;
                    logic       em;
                    en = q_ev_next.pop_front();
                    em = q_ev_mc.pop_front();
                    chk(cur_page == en, "R8", "next page at completion", cur_page, en);
                    chk(stat_mcast == em, "R9", "multicast status", stat_mcast, em);
                    chk(stat_rx_ok == 1'b1, "R9", "receive-OK status", stat_rx_ok, 1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R5", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cfg_stop = 1'b0; cfg_promisc = 1'b0; cfg_bcast_en = 1'b0;
        cfg_mcast_en = 1'b0; cfg_runt_ok = 1'b0;
        cfg_page_start = 8'h40; cfg_page_stop = 8'h48; cfg_boundary = 8'h40;
        cfg_station = 48'h6655_4433_2210;
        cfg_hash = 64'h0;
        cfg_hash[37] = 1'b1;
        cur_wr = 1'b0; cur_wdata = 8'h00;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
        rx_len = 16'h0; rx_dest = 48'h0; rx_hash_idx = 6'h0;
        bm_cur = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(cur_page == 8'h00, "R11", "reset current page", cur_page, 0);
        chk(ram_we == 1'b0, "R11", "reset write strobe", ram_we, 0);
        chk(rx_done == 1'b0, "R11", "reset done", rx_done, 0);
        chk(stat_rx_ok == 1'b0, "R11", "reset receive-OK", stat_rx_ok, 0);
        chk(stat_mcast == 1'b0, "R11", "reset multicast status", stat_mcast, 0);
        running = 1'b1;

        load_cur(8'h40);                                                       // R10
        send_frame(48'h6655_4433_2210, 100, 6'd0, 1'b0, "R5");                // unicast hit
        send_frame(48'h6655_4433_2212, 100, 6'd0, 1'b0, "R4");                // unicast miss
        send_frame(48'hFFFF_FFFF_FFFF, 64, 6'd0, 1'b0, "R4");                 // broadcast off
        cfg_bcast_en = 1'b1;
        send_frame(48'hFFFF_FFFF_FFFF, 64, 6'd0, 1'b0, "R4");                 // broadcast on
        cfg_mcast_en = 1'b1;
        send_frame(48'h0000_5E00_0001, 70, 6'd36, 1'b0, "R4");               // hash bit clear
        send_frame(48'h0000_5E00_0001, 70, 6'd37, 1'b0, "R9");               // hash bit set
        cfg_promisc = 1'b1;
        send_frame(48'hAABB_CCDD_EE02, 80, 6'd0, 1'b0, "R4");                // promiscuous
        cfg_promisc = 1'b0;
        send_frame(48'h6655_4433_2210, 30, 6'd0, 1'b0, "R3");                // runt dropped
        cfg_runt_ok = 1'b1;
        send_frame(48'h6655_4433_2210, 30, 6'd0, 1'b0, "R3");                // runt kept
        cfg_runt_ok = 1'b0;
        send_frame(48'h6655_4433_2210, 50, 6'd0, 1'b0, "R3");                // short padded
        cfg_stop = 1'b1;
        send_frame(48'h6655_4433_2210, 64, 6'd0, 1'b0, "R1");                // stopped
        cfg_stop = 1'b0;
        cfg_page_start = 8'h00;
        send_frame(48'h6655_4433_2210, 64, 6'd0, 1'b0, "R1");                // start page 0
        cfg_page_start = 8'h40;
        load_cur(8'h47);
        send_frame(48'h6655_4433_2210, 300, 6'd0, 1'b0, "R2");               // 1 free, needs 2
        cfg_boundary = 8'h44;
        send_frame(48'h6655_4433_2210, 300, 6'd0, 1'b0, "R6");               // wraps mid-frame
        cfg_boundary = 8'h42;
        send_frame(48'h6655_4433_2210, 300, 6'd0, 1'b0, "R2");               // cur<bnd, too big
        send_frame(48'h6655_4433_2210, 200, 6'd0, 1'b0, "R2");               // exact fit
        send_frame(48'h6655_4433_2210, 64, 6'd0, 1'b1, "R10");               // load vs commit

        repeat (10) @(negedge clk);
        chk(q_addr.size() == 0, "R7", "outstanding expected writes", q_addr.size(), 0);
        chk(q_ev_next.size() == 0, "R9", "outstanding completions", q_ev_next.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule